// File: doc/BRIEF.md
# Byte-Wide CRC-32 Frame Engine

This block computes the 32-bit cyclic redundancy checksum of a frame and takes in one byte per clock. Each byte and the current accumulator pass through one flat XOR network, and the result is the next accumulator value. The arithmetic uses the reflected form of polynomial 0x04C11DB7, so the XOR constant is 0xEDB88320. Each byte enters bit 0 first, and the register shifts toward its least significant bit.

In transmit mode the engine takes in the payload. After the last byte it sends out the inverted checksum as four trailing bytes, which the caller appends to the frame. In receive mode the caller passes in the whole frame with its four checksum bytes. One cycle after the last byte, the engine raises a one-cycle pass flag if the accumulator holds the fixed residue that every error-free frame leaves behind.

Top module: `crc32_frame_engine`

## Requirements
- R1: Each accepted byte updates the accumulator in a single clock. A frame's transmitted checksum equals the inverted result of the reflected 0x04C11DB7 CRC with all-ones start, bytes taken bit 0 first. The nine ASCII bytes "123456789" yield 0xCBF43926.
- R2: A byte accepted with `sof` high is absorbed into an accumulator of all ones, not into the previous value. This also holds in the middle of a frame, and the partial result is then discarded.
- R3: A cycle with `in_valid` low leaves the accumulator unchanged, so idle gaps inside a frame do not alter its checksum.
- R4: In transmit mode (`tx_mode` = 1), an accepted byte with `eof` high produces the inverted checksum on `out_data` over the next four cycles, least significant byte first. The first byte appears in the cycle after the `eof` edge.
- R5: `busy` is high for exactly those four cycles. Inputs presented while `busy` is high are ignored, including `sof`, `eof` and data.
- R6: In receive mode (`tx_mode` = 0), a frame with its four checksum bytes appended passes only if the accumulator then equals 0xDEBB20E3. Any single flipped bit in such a frame makes it fail.
- R7: `frame_ok` is registered. It is high only in the single cycle after the `eof` byte of a passing receive frame, and low at all other times.
- R8: After reset, `busy` and `frame_ok` are low and `out_data` is zero.
- R9: `sof` and `eof` act only together with an accepted byte. A one-byte frame may carry both strobes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 1 | 1 = transmit (append checksum), 0 = receive (check residue); sampled with the `eof` byte |
| sof | input | 1 | First byte of a frame; restarts the accumulator |
| in_valid | input | 1 | `in_data` holds a byte this cycle |
| in_data | input | 8 | Frame byte |
| eof | input | 1 | Last byte of a frame |
| busy | output | 1 | Checksum byte valid on `out_data`; input ignored |
| out_data | output | 8 | Outgoing checksum byte, zero when `busy` is low |
| frame_ok | output | 1 | One-cycle pass flag for a received frame |

## Verification
The assertions assume that the caller keeps `sof` and `eof` meaningful only alongside `in_valid`. They also assume that `tx_mode` is steady when the `eof` byte is accepted. The checks on receive pass and on the first transmit byte compare against the accumulator, so they rely on nothing being accepted while `busy` is high. The stimulus deliberately offers bytes with both strobes set during `busy`, and the bench confirms that these bytes change nothing at the ports. Frames are always started with `sof`, and gaps are made only by lowering `in_valid`.

// File: rtl/crc32_frame_engine.sv
module crc32_frame_engine #(
  parameter logic [31:0] POLY_REFL = 32'hEDB88320,
  parameter logic [31:0] SEED      = 32'hFFFFFFFF,
  parameter logic [31:0] RESIDUE   = 32'hDEBB20E3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_mode,
  input  logic       sof,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  input  logic       eof,
  output logic       busy,
  output logic [7:0] out_data,
  output logic       frame_ok
);

  localparam int TAPS = 40;

  // elaboration-time only: used to derive the flat XOR masks
  function automatic logic [31:0] bit_walk(logic [31:0] c, logic [7:0] d);
    logic fb;
    for (int k = 0; k < 8; k++) begin
      fb = c[0] ^ d[k];
      c  = {1'b0, c[31:1]} ^ (fb ? POLY_REFL : 32'h0);
    end
    return c;
  endfunction

  function automatic logic [TAPS-1:0] row_mask(int j);
    logic [TAPS-1:0] m;
    logic [31:0] v;
    for (int i = 0; i < TAPS; i++) begin
      if (i < 32) v = bit_walk(32'h1 << i, 8'h0);
      else        v = bit_walk(32'h0, 8'(1 << (i - 32)));
      m[i] = v[j];
    end
    return m;
  endfunction

  logic [31:0] acc_q, acc_base, acc_nx;
  logic [31:0] tx_sh;
  logic [2:0]  tx_left;
  logic        take;

  assign busy     = tx_left != 3'd0;
  assign take     = in_valid & ~busy;
  assign acc_base = sof ? SEED : acc_q;
  assign out_data = busy ? tx_sh[7:0] : 8'h00;

  for (genvar j = 0; j < 32; j++) begin : g_xor
    localparam logic [TAPS-1:0] MASK = row_mask(j);
    assign acc_nx[j] = ^({in_data, acc_base} & MASK);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= SEED;
    else if (take) acc_q <= acc_nx;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_left <= 3'd0;
      tx_sh   <= 32'h0;
    end else if (take && eof && tx_mode) begin
      tx_left <= 3'd4;
      tx_sh   <= ~acc_nx;
    end else if (busy) begin
      tx_left <= tx_left - 3'd1;
      tx_sh   <= {8'h00, tx_sh[31:8]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) frame_ok <= 1'b0;
    else        frame_ok <= take && eof && !tx_mode && (acc_nx == RESIDUE);
  end

  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && !busy) |=> $stable(acc_q));

  // R5
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(in_valid && eof && tx_mode));

  // R5
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_left == 3'd1) |=> !busy);

  // R4
  tx_first_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (out_data == ~acc_q[7:0]));

  // R7
  ok_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> $past(in_valid && !busy && eof && !tx_mode));

  // R6
  ok_residue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |-> (acc_q == RESIDUE));

  // R7
  ok_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_ok && busy));

endmodule

// File: tb/crc32_frame_engine_test.sv
`timescale 1ns/1ps
module crc32_frame_engine_test;
  logic clk = 1'b0;
  logic rst_n, tx_mode, sof, in_valid, eof;
  logic [7:0] in_data;
  logic busy, frame_ok;
  logic [7:0] out_data;

  always #2.5 clk = ~clk;

  crc32_frame_engine uut (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .sof(sof),
    .in_valid(in_valid), .in_data(in_data), .eof(eof),
    .busy(busy), .out_data(out_data), .frame_ok(frame_ok)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [7:0] mem [0:47];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(int n);
    logic [31:0] c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        if (c[0] ^ mem[i][k]) c = (c >> 1) ^ 32'hEDB88320;
        else                  c = c >> 1;
      end
    return ~c;
  endfunction

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; sof = s; eof = e;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 1'b0; sof = 1'b0; eof = 1'b0; in_data = 8'h00;
  endtask

  task automatic fill(int n, int seed);
    for (int i = 0; i < n; i++) mem[i] = 8'((i * 29 + seed * 7 + 3) ^ (i >> 1));
  endtask

  // transmit mem[0..n-1], optionally with idle gaps; check appended bytes
  task automatic tx_frame(int n, bit gaps, input string req);
    logic [31:0] exp = ref_crc(n);
    tx_mode = 1'b1;
    for (int i = 0; i < n; i++) begin
      put(mem[i], i == 0, i == n - 1);
      if (gaps && (i % 3 == 1) && i != n - 1) begin idle(); idle(); end
    end
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      check({req, " R5 busy"}, 32'(busy), 32'd1);
      check({req, " R4 byte"}, 32'(out_data), 32'(exp[8*b +: 8]));
      // R5: offered during busy, must be ignored
      in_valid = 1'b1; sof = 1'b1; eof = 1'b1; in_data = 8'hA5;
    end
    @(negedge clk);
    check("R5 busy drops after four bytes", 32'(busy), 32'd0);
    check("R4 out_data idle", 32'(out_data), 32'd0);
    in_valid = 1'b0; sof = 1'b0; eof = 1'b0;
  endtask

  task automatic rx_frame(int n, logic exp_ok, input string req);
    tx_mode = 1'b0;
    for (int i = 0; i < n; i++) put(mem[i], i == 0, i == n - 1);
    idle();
    check({req, " R7 flag"}, 32'(frame_ok), 32'(exp_ok));
    idle();
    check("R7 flag is one cycle", 32'(frame_ok), 32'd0);
  endtask

  task automatic append_crc(int n);
    logic [31:0] c = ref_crc(n);
    for (int b = 0; b < 4; b++) mem[n + b] = c[8*b +: 8];
  endtask

  initial begin
    rst_n = 1'b0; tx_mode = 1'b0; sof = 1'b0; in_valid = 1'b0; eof = 1'b0; in_data = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8
    check("R8 busy at reset", 32'(busy), 32'd0);
    check("R8 frame_ok at reset", 32'(frame_ok), 32'd0);
    check("R8 out_data at reset", 32'(out_data), 32'd0);

    // R1 known vector "123456789"
    for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
    check("R1 bench model vector", ref_crc(9), 32'hCBF43926);
    tx_frame(9, 0, "R1 vector");

    // R1, R3, R9: length sweep with and without gaps, then receive each
    for (int n = 1; n <= 20; n++) begin
      fill(n, n);
      tx_frame(n, n[0], "R1 sweep");
      append_crc(n);
      rx_frame(n + 4, 1'b1, "R6 good frame");
    end

    // R2: abandoned partial frame, then a fresh sof
    fill(12, 5);
    tx_mode = 1'b1;
    put(8'h11, 1'b1, 1'b0); put(8'h22, 1'b0, 1'b0); put(8'h33, 1'b0, 1'b0);
    tx_frame(12, 0, "R2 restart");
    // R2: sof arriving inside a receive frame
    append_crc(12);
    tx_mode = 1'b0;
    put(8'h7E, 1'b1, 1'b0); put(8'h81, 1'b0, 1'b0);
    rx_frame(16, 1'b1, "R2 rx restart");

    // R6: every single-bit flip of a short frame fails
    for (int bitpos = 0; bitpos < 64; bitpos++) begin
      fill(4, 9);
      append_crc(4);
      mem[bitpos / 8][bitpos % 8] = ~mem[bitpos / 8][bitpos % 8];
      rx_frame(8, 1'b0, "R6 flipped bit");
    end

    // R7: receive frame ending without checksum is flagged bad
    fill(6, 2);
    rx_frame(6, 1'b0, "R7 no checksum");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule